// File: doc/BRIEF.md
# Per-Die, Per-Plane Flash Status Poller

This block reads the status byte of one chosen die and plane on a flash bus where several dies share one chip enable. A scheduler gives it a die index, a plane index, a row address, a status bit to watch and the value that bit should reach. The block sends the per-plane status command (78h) and three row-address bytes. It places the die and the plane in the address bits that the flash decodes for them. It then samples the status byte again and again under the same chip enable. It never sends the command a second time. Sampling stops when the watched bit reaches its target or when the number of samples reaches a limit.

The block keeps two facts about every die. The first is whether the die's last recorded operation leaves the per-plane status command forbidden. That is true after power-on, after a one-time-programmable page access and after a paired-plane page read. The second is whether the die may still be busy. From these it tells the scheduler which dies are idle. It also tells the scheduler whether the shared single-die status command (70h) is safe, which is not the case when two dies could answer it at once.

Top module: `nand_die_status_poller`

## Requirements
- R1: A poll starts with one command cycle carrying 78h, followed by exactly three address cycles. Byte 0 is row[7:0], byte 1 is row[15:8] and byte 2 is row[18:16] in bits 2:0 with zeros above. The plane index overrides row bit 6, which is bit 6 of byte 0. The die index overrides row bit 18, which is bit 2 of byte 2.
- R2: Each poll issues the command exactly once, however many samples it takes. Chip enable (bus_ce_n low) is held from the command cycle to the last sample, and every strobe occurs while it is held.
- R3: Between two consecutive samples of one poll the bus stays idle for exactly req_interval cycles. Zero means back-to-back samples.
- R4: A poll ends at the first sample whose bit req_bit equals req_target. poll_done pulses for one cycle after that sample. poll_status then holds the sampled byte, and st_ready, st_array_ready and st_fail show bits 6, 5 and 0 of that byte.
- R5: If req_limit samples pass without a match, the poll ends with poll_done and poll_timeout pulsing together and poll_status holding the last sample. A limit of 0 is treated as 1.
- R6: Each die carries a "status command forbidden" flag. The flag is set after reset, and it is also set by an op_kind of 1 (power-on), 2 (one-time-programmable access) or 3 (paired-plane page read). An op_kind of 0 (general) clears it. A request to a die whose flag is set produces a req_rejected pulse one cycle later and no bus activity.
- R7: die_idle[d] is 1 after reset. It goes to 0 one cycle after any op_valid for die d. It returns to 1 one cycle after a poll of die d ends with status bit 5 set.
- R8: plain_status_ok is 1 exactly when at most one die has die_idle low.
- R9: req_ready is high only when no poll is running. A request made while a poll runs is ignored and starts no new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Poll request |
| req_ready | output | 1 | No poll in progress |
| req_die | input | 1 | Die index |
| req_plane | input | 1 | Plane index |
| req_row | input | 19 | Block/page row address |
| req_bit | input | 3 | Status bit to watch |
| req_target | input | 1 | Value that ends the poll |
| req_interval | input | 8 | Idle cycles between samples |
| req_limit | input | 16 | Maximum samples (0 means 1) |
| req_rejected | output | 1 | Request refused: status command forbidden on that die |
| op_valid | input | 1 | An operation was issued to a die |
| op_die | input | 1 | Die of that operation |
| op_kind | input | 2 | 0 general, 1 power-on, 2 one-time-programmable, 3 paired-plane read |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_cmd | output | 1 | Command cycle strobe |
| bus_addr | output | 1 | Address cycle strobe |
| bus_rd | output | 1 | Status sample strobe |
| bus_dout | output | 8 | Command or address byte |
| bus_din | input | 8 | Status byte from the flash, sampled during bus_rd |
| poll_done | output | 1 | Poll finished (one-cycle pulse) |
| poll_timeout | output | 1 | Poll finished without a match |
| poll_status | output | 8 | Last sampled status byte |
| st_ready | output | 1 | Status bit 6 |
| st_array_ready | output | 1 | Status bit 5 |
| st_fail | output | 1 | Status bit 0 |
| die_idle | output | 2 | Per-die idle view |
| plain_status_ok | output | 2'b1 → 1 | 70h status command safe |

## Verification
The hardest case to reach is a watched bit that changes at a chosen sample index, and in particular exactly at the last sample the limit allows. That case separates a real match from a timeout. The bench's flash model therefore returns one status byte before a scripted read count and a different byte after it, and it decodes die and plane from the address bytes it has captured. Random requests sweep the flip point, the limit (including 0), the interval (including 0) and the watched bit. Scripted operation events move dies in and out of the forbidden and busy states around these polls, and stray requests are injected while a poll runs.

// File: rtl/nand_poll_pkg.sv
// Shared types for the per-die status poller.
// Assumes: a single 78h command value and three row-address bytes.
package nand_poll_pkg;
    typedef enum logic [1:0] {
        OPK_GENERAL    = 2'd0,
        OPK_POWER_ON   = 2'd1,
        OPK_OTP        = 2'd2,
        OPK_PAIR_READ  = 2'd3
    } op_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_CMD, SQ_AD0, SQ_AD1, SQ_AD2, SQ_SAMPLE, SQ_GAP
    } sq_state_e;

    localparam logic [7:0] PLANE_STATUS_CMD = 8'h78;
    localparam int ADDR_BYTES = 3;
endpackage

// File: rtl/nand_poll_seq.sv
// Bus sequencer: sends 78h and three row bytes, then samples the status
// byte repeatedly under one chip enable until a bit matches or the limit hits.
// Assumes: one bus cycle per clock, bus_din valid during the bus_rd cycle.
module nand_poll_seq
    import nand_poll_pkg::*;
#(
    parameter int ROW_W = 19,
    parameter int IVL_W = 8,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ROW_W-1:0] row,
    input  logic [2:0]       bit_sel,
    input  logic             target,
    input  logic [IVL_W-1:0] interval,
    input  logic [TMO_W-1:0] limit,
    output logic             idle,
    output logic             bus_ce_n,
    output logic             bus_cmd,
    output logic             bus_addr,
    output logic             bus_rd,
    output logic [7:0]       bus_dout,
    input  logic [7:0]       bus_din,
    output logic [7:0]       stat,
    output logic             done,
    output logic             timed_out
);
    localparam int PAD_W = 8 * ADDR_BYTES;

    sq_state_e        st;
    logic [PAD_W-1:0] row_q;
    logic [2:0]       bit_q;
    logic             tgt_q;
    logic [IVL_W-1:0] ivl_q;
    logic [IVL_W-1:0] gap_q;
    logic [TMO_W-1:0] lim_q;
    logic [TMO_W-1:0] rd_q;
    logic             hit;
    logic             last;

    assign hit  = (bus_din[bit_q] == tgt_q);
    assign last = (rd_q == lim_q - TMO_W'(1));

    // Sequencer state, request capture and sample evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SQ_IDLE;
            row_q     <= '0;
            bit_q     <= '0;
            tgt_q     <= 1'b0;
            ivl_q     <= '0;
            gap_q     <= '0;
            lim_q     <= TMO_W'(1);
            rd_q      <= '0;
            stat      <= '0;
            done      <= 1'b0;
            timed_out <= 1'b0;
        end else begin
            done      <= 1'b0;
            timed_out <= 1'b0;
            case (st)
                SQ_IDLE: if (start) begin
                    row_q <= PAD_W'(row);
                    bit_q <= bit_sel;
                    tgt_q <= target;
                    ivl_q <= interval;
                    lim_q <= (limit == '0) ? TMO_W'(1) : limit;
                    rd_q  <= '0;
                    st    <= SQ_CMD;
                end
                SQ_CMD: st <= SQ_AD0;
                SQ_AD0: st <= SQ_AD1;
                SQ_AD1: st <= SQ_AD2;
                SQ_AD2: st <= SQ_SAMPLE;
                SQ_SAMPLE: begin
                    stat <= bus_din;
                    rd_q <= rd_q + TMO_W'(1);
                    if (hit || last) begin
                        st        <= SQ_IDLE;
                        done      <= 1'b1;
                        timed_out <= !hit;
                    end else if (ivl_q == '0) begin
                        st <= SQ_SAMPLE;
                    end else begin
                        gap_q <= ivl_q - IVL_W'(1);
                        st    <= SQ_GAP;
                    end
                end
                SQ_GAP: begin
                    if (gap_q == '0) st <= SQ_SAMPLE;
                    else             gap_q <= gap_q - IVL_W'(1);
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // Bus byte for the current command or address cycle.
    always_comb begin
        case (st)
            SQ_CMD:  bus_dout = PLANE_STATUS_CMD;
            SQ_AD0:  bus_dout = row_q[7:0];
            SQ_AD1:  bus_dout = row_q[15:8];
            SQ_AD2:  bus_dout = row_q[23:16];
            default: bus_dout = 8'h00;
        endcase
    end

    assign idle     = (st == SQ_IDLE);
    assign bus_ce_n = (st == SQ_IDLE);
    assign bus_cmd  = (st == SQ_CMD);
    assign bus_addr = (st == SQ_AD0) || (st == SQ_AD1) || (st == SQ_AD2);
    assign bus_rd   = (st == SQ_SAMPLE);

    AST_CMD_THEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd |=> bus_addr); // R1
    AST_STROBE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd || bus_addr || bus_rd) |-> !bus_ce_n); // R2
    AST_DONE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_rd)); // R4
    AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        timed_out |-> done); // R5
endmodule

// File: rtl/nand_die_hist.sv
// Per-die history: a "status command forbidden" flag and a "may be busy"
// flag for each die, plus the single-die status command permission.
// Assumes: op_valid is pulsed once per operation issued to a die.
module nand_die_hist
    import nand_poll_pkg::*;
#(
    parameter int NDIE  = 2,
    parameter int DIE_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [DIE_W-1:0] op_die,
    input  op_kind_e         op_kind,
    input  logic             poll_done,
    input  logic [DIE_W-1:0] poll_die,
    input  logic             poll_ardy,
    output logic [NDIE-1:0]  blocked,
    output logic [NDIE-1:0]  die_idle,
    output logic             plain_ok
);
    logic [NDIE-1:0] busy;

    for (genvar d = 0; d < NDIE; d++) begin : g_die
        logic blk_q;
        logic bsy_q;
        // Track forbidden-command and busy state for die d.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                blk_q <= 1'b1;
                bsy_q <= 1'b0;
            end else if (op_valid && op_die == DIE_W'(d)) begin
                blk_q <= (op_kind != OPK_GENERAL);
                bsy_q <= 1'b1;
            end else if (poll_done && poll_die == DIE_W'(d) && poll_ardy) begin
                bsy_q <= 1'b0;
            end
        end
        assign blocked[d]  = blk_q;
        assign busy[d]     = bsy_q;
        assign die_idle[d] = !bsy_q;
    end

    // Count possibly busy dies to decide if the shared status command is safe.
    always_comb begin
        int cnt;
        cnt = 0;
        for (int i = 0; i < NDIE; i++) cnt += int'(busy[i]);
        plain_ok = (cnt <= 1);
    end

    AST_OP_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> !die_idle[$past(op_die)]); // R7
    AST_RESTRICTED_OP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind != OPK_GENERAL) |=> blocked[$past(op_die)]); // R6
endmodule

// File: rtl/nand_die_status_poller.sv
// Top: places die/plane into the row bits the flash decodes, refuses
// polls of dies where 78h is forbidden, and runs the bus sequencer.
// Assumes: ROW_W covers DIE_LSB+DIE_W and fits in three address bytes.
module nand_die_status_poller
    import nand_poll_pkg::*;
#(
    parameter int NDIE      = 2,
    parameter int ROW_W     = 19,
    parameter int PLANE_BIT = 6,
    parameter int DIE_LSB   = 18,
    parameter int IVL_W     = 8,
    parameter int TMO_W     = 16,
    localparam int DIE_W    = $clog2(NDIE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [DIE_W-1:0] req_die,
    input  logic             req_plane,
    input  logic [ROW_W-1:0] req_row,
    input  logic [2:0]       req_bit,
    input  logic             req_target,
    input  logic [IVL_W-1:0] req_interval,
    input  logic [TMO_W-1:0] req_limit,
    output logic             req_rejected,
    input  logic             op_valid,
    input  logic [DIE_W-1:0] op_die,
    input  logic [1:0]       op_kind,
    output logic             bus_ce_n,
    output logic             bus_cmd,
    output logic             bus_addr,
    output logic             bus_rd,
    output logic [7:0]       bus_dout,
    input  logic [7:0]       bus_din,
    output logic             poll_done,
    output logic             poll_timeout,
    output logic [7:0]       poll_status,
    output logic             st_ready,
    output logic             st_array_ready,
    output logic             st_fail,
    output logic [NDIE-1:0]  die_idle,
    output logic             plain_status_ok
);
    logic             idle;
    logic             accept;
    logic             refuse;
    logic [NDIE-1:0]  blocked;
    logic [DIE_W-1:0] die_q;
    logic [ROW_W-1:0] row_sel;

    assign req_ready = idle;
    assign accept    = req_valid && idle && !blocked[req_die];
    assign refuse    = req_valid && idle &&  blocked[req_die];

    // Overwrite plane and die bits of the row with the chosen indices.
    always_comb begin
        row_sel                    = req_row;
        row_sel[PLANE_BIT]         = req_plane;
        row_sel[DIE_LSB +: DIE_W]  = req_die;
    end

    // Remember the polled die and flag refused requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            die_q        <= '0;
            req_rejected <= 1'b0;
        end else begin
            req_rejected <= refuse;
            if (accept) die_q <= req_die;
        end
    end

    nand_poll_seq #(.ROW_W(ROW_W), .IVL_W(IVL_W), .TMO_W(TMO_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept), .row(row_sel),
        .bit_sel(req_bit), .target(req_target), .interval(req_interval),
        .limit(req_limit), .idle(idle), .bus_ce_n(bus_ce_n),
        .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_dout(bus_dout), .bus_din(bus_din), .stat(poll_status),
        .done(poll_done), .timed_out(poll_timeout)
    );

    nand_die_hist #(.NDIE(NDIE), .DIE_W(DIE_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_die(op_die),
        .op_kind(op_kind_e'(op_kind)), .poll_done(poll_done),
        .poll_die(die_q), .poll_ardy(poll_status[5]), .blocked(blocked),
        .die_idle(die_idle), .plain_ok(plain_status_ok)
    );

    assign st_ready       = poll_status[6];
    assign st_array_ready = poll_status[5];
    assign st_fail        = poll_status[0];

    AST_REJECT_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        req_rejected |-> !bus_cmd); // R6
    AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> !bus_cmd); // R9
endmodule

// File: tb/nand_die_status_poller_tb.sv
module nand_die_status_poller_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, req_valid, req_ready, req_plane, req_target, req_rejected;
    logic [0:0] req_die, op_die;
    logic [18:0] req_row;
    logic [2:0] req_bit;
    logic [7:0] req_interval;
    logic [15:0] req_limit;
    logic op_valid;
    logic [1:0] op_kind;
    logic bus_ce_n, bus_cmd, bus_addr, bus_rd;
    logic [7:0] bus_dout, bus_din, poll_status;
    logic poll_done, poll_timeout, st_ready, st_array_ready, st_fail;
    logic [1:0] die_idle;
    logic plain_status_ok;

    nand_die_status_poller u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_die(req_die), .req_plane(req_plane), .req_row(req_row),
        .req_bit(req_bit), .req_target(req_target), .req_interval(req_interval),
        .req_limit(req_limit), .req_rejected(req_rejected), .op_valid(op_valid),
        .op_die(op_die), .op_kind(op_kind), .bus_ce_n(bus_ce_n),
        .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_dout(bus_dout), .bus_din(bus_din), .poll_done(poll_done),
        .poll_timeout(poll_timeout), .poll_status(poll_status),
        .st_ready(st_ready), .st_array_ready(st_array_ready), .st_fail(st_fail),
        .die_idle(die_idle), .plain_status_ok(plain_status_ok)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Flash model: status before / after a scripted read count, per die and plane.
    logic [7:0] m_pre [2][2];
    logic [7:0] m_post[2][2];
    int m_flip = 0;
    int rd_cnt = 0;
    bit rd_pend = 0;
    logic [7:0] abuf[3];
    int a_idx = 0, cmd_cnt = 0, cmd_bad = 0, ce_bad = 0;
    int gap = 0, gap_bad = 0, exp_ivl = 0;
    bit seen_rd = 0;
    bit exp_busy[2];
    bit exp_blk[2];

    always_comb begin
        if (rd_cnt < m_flip) bus_din = m_pre[abuf[2][2]][abuf[0][6]];
        else                 bus_din = m_post[abuf[2][2]][abuf[0][6]];
    end

    always @(negedge clk) begin
        if (rd_pend) begin rd_cnt++; rd_pend = 0; end
        if ((bus_cmd || bus_addr || bus_rd) && bus_ce_n) ce_bad++;
        if (bus_cmd) begin
            cmd_cnt++;
            if (bus_dout != 8'h78) cmd_bad++;
            rd_cnt = 0; seen_rd = 0; gap = 0; a_idx = 0;
        end
        if (bus_addr) begin
            if (a_idx < 3) abuf[a_idx] = bus_dout;
            a_idx++;
        end
        if (bus_rd) begin
            if (seen_rd && gap != exp_ivl) gap_bad++;
            seen_rd = 1; gap = 0; rd_pend = 1;
        end else if (seen_rd && !bus_ce_n) begin
            gap++;
        end
    end

    task automatic expect_poll(input logic [7:0] pre, input logic [7:0] post,
                               input int flip, input int b, input bit tgt,
                               input int lim, output int reads,
                               output logic [7:0] st, output bit tmo);
        int l;
        l = (lim == 0) ? 1 : lim;
        tmo = 1; reads = l; st = 8'h00;
        for (int i = 0; i < l; i++) begin
            st = (i < flip) ? pre : post;
            if (st[b] == tgt) begin reads = i + 1; tmo = 0; break; end
        end
    endtask

    task automatic chk_die_view(input string rq);
        int nb;
        nb = int'(exp_busy[0]) + int'(exp_busy[1]);
        chk(die_idle == {!exp_busy[1], !exp_busy[0]}, {rq, " R7 die_idle"},
            int'(die_idle), int'({!exp_busy[1], !exp_busy[0]}));
        chk(plain_status_ok == (nb <= 1), {rq, " R8 plain_status_ok"},
            int'(plain_status_ok), int'(nb <= 1));
    endtask

    task automatic op_event(input int die, input int kind);
        @(negedge clk);
        op_valid = 1; op_die = die[0:0]; op_kind = kind[1:0];
        @(negedge clk); #1;
        op_valid = 0;
        exp_busy[die] = 1;
        exp_blk[die]  = (kind != 0);
        chk_die_view("op_event");
    endtask

    task automatic do_poll(input int die, input int plane, input logic [18:0] row,
                           input int b, input bit tgt, input int ivl, input int lim,
                           input logic [7:0] pre, input logic [7:0] post, input int flip);
        int c0, w, reads;
        bit tmo, rej;
        logic [7:0] est;
        logic [18:0] erow;
        rej = exp_blk[die];
        @(negedge clk);
        m_pre[die][plane] = pre; m_post[die][plane] = post; m_flip = flip;
        exp_ivl = ivl; gap_bad = 0; c0 = cmd_cnt;
        req_die = die[0:0]; req_plane = plane[0]; req_row = row; req_bit = b[2:0];
        req_target = tgt; req_interval = ivl[7:0]; req_limit = lim[15:0];
        req_valid = 1;
        @(negedge clk); #1;
        chk(req_rejected == rej, "R6 rejected pulse", int'(req_rejected), int'(rej));
        if (rej) begin
            req_valid = 0;
            repeat (6) @(negedge clk);
            #1;
            chk(cmd_cnt == c0 && req_ready, "R6 no bus activity on refused die",
                cmd_cnt - c0, 0);
            return;
        end
        chk(!req_ready, "R9 busy during poll", int'(req_ready), 0);
        req_die = ~req_die;   // stray request, must be ignored
        w = 0;
        while (!poll_done && w < 4000) begin
            @(negedge clk); #1;
            w++;
            req_valid = 0;
        end
        expect_poll(pre, post, flip, b, tgt, lim, reads, est, tmo);
        chk(poll_done, "R4 poll_done reached", int'(poll_done), 1);
        chk(rd_cnt == reads, "R4/R5 sample count", rd_cnt, reads);
        chk(poll_status == est, "R4 poll_status", int'(poll_status), int'(est));
        chk(poll_timeout == tmo, "R5 poll_timeout", int'(poll_timeout), int'(tmo));
        chk({st_ready, st_array_ready, st_fail} == {est[6], est[5], est[0]},
            "R4 status bits", int'({st_ready, st_array_ready, st_fail}),
            int'({est[6], est[5], est[0]}));
        chk(cmd_cnt == c0 + 1 && cmd_bad == 0, "R2 single 78h command",
            cmd_cnt - c0, 1);
        chk(ce_bad == 0, "R2 strobes under chip enable", ce_bad, 0);
        chk(a_idx == 3, "R1 three address cycles", a_idx, 3);
        erow = row; erow[6] = plane[0]; erow[18] = die[0];
        chk(abuf[0] == erow[7:0], "R1 address byte 0", int'(abuf[0]), int'(erow[7:0]));
        chk(abuf[1] == erow[15:8], "R1 address byte 1", int'(abuf[1]), int'(erow[15:8]));
        chk(abuf[2] == {5'b0, erow[18:16]}, "R1 address byte 2", int'(abuf[2]),
            int'({5'b0, erow[18:16]}));
        chk(gap_bad == 0, "R3 sample spacing", gap_bad, 0);
        chk(req_ready, "R9 ready after done", int'(req_ready), 1);
        if (est[5]) exp_busy[die] = 0;
        @(negedge clk); #1;
        chk_die_view("after poll");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int d = 0; d < 2; d++) begin
            exp_busy[d] = 0; exp_blk[d] = 1;
            for (int p = 0; p < 2; p++) begin m_pre[d][p] = 0; m_post[d][p] = 0; end
        end
        for (int i = 0; i < 3; i++) abuf[i] = 0;
        rst_n = 0; req_valid = 0; req_die = 0; req_plane = 0; req_row = 0;
        req_bit = 0; req_target = 0; req_interval = 0; req_limit = 0;
        op_valid = 0; op_die = 0; op_kind = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk(req_ready && bus_ce_n && !poll_done, "R9 reset idle", int'(req_ready), 1);
        chk_die_view("reset");
        // R6: power-on leaves both dies forbidden
        do_poll(0, 0, 19'h0, 5, 1, 0, 4, 8'h60, 8'h60, 0);
        do_poll(1, 1, 19'h0, 5, 1, 0, 4, 8'h60, 8'h60, 0);
        op_event(0, 0);
        op_event(1, 0);
        // R1/R3/R4: plane bit forced against row bit 6, die bit 1, interval 2
        do_poll(1, 1, 19'h2_A5B3 & ~19'h40, 5, 1, 2, 10, 8'h80, 8'hE1, 3);
        // R5: never matches, limit 3, then limit 0 treated as 1
        do_poll(0, 0, 19'h4_1234, 6, 1, 0, 3, 8'h01, 8'h01, 0);
        do_poll(0, 1, 19'h0_00FF, 6, 1, 1, 0, 8'h01, 8'h01, 0);
        // R5 edge: flip on the very last allowed sample
        do_poll(0, 0, 19'h1_1111, 5, 1, 0, 4, 8'h00, 8'h20, 3);
        do_poll(0, 0, 19'h1_1111, 5, 1, 0, 3, 8'h00, 8'h20, 3);
        // R6: restricted kinds forbid, general clears
        op_event(0, 2);
        do_poll(0, 0, 19'h0, 5, 1, 0, 2, 8'h60, 8'h60, 0);
        op_event(0, 0);
        do_poll(0, 0, 19'h3, 5, 1, 0, 2, 8'h60, 8'h60, 0);
        op_event(1, 3);
        do_poll(1, 0, 19'h3, 5, 1, 0, 2, 8'h60, 8'h60, 0);
        op_event(1, 1);
        op_event(1, 0);
        // Random mix
        for (int it = 0; it < 40; it++) begin
            if ($urandom_range(0, 3) == 0) op_event($urandom_range(0, 1), $urandom_range(0, 3));
            do_poll($urandom_range(0, 1), $urandom_range(0, 1), 19'($urandom),
                    $urandom_range(0, 7), 1'($urandom), $urandom_range(0, 3),
                    $urandom_range(0, 6), 8'($urandom), 8'($urandom),
                    $urandom_range(0, 5));
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule